// File: doc/BRIEF.md
# Quadword atomic load unit

This unit sits beside a load/store pipeline. It watches alternate-space load and store instruction words and picks out the two quadword-load address space identifiers: 0x34 selects a big-endian load and 0x3C selects a little-endian load. It then runs four checks, covering privilege, alignment, opcode and cacheability. If a check fails, it reports exactly one exception. If all checks pass, it issues one indivisible 128-bit physical read and commits the result to an even/odd pair of 64-bit registers in a single cycle.

The effective address is formed in one of two ways. When the immediate bit is clear, it is the sum of two register operands. When the immediate bit is set, it is a register operand plus a sign-extended 13-bit offset. The address space identifier comes from the instruction word when the immediate bit is clear, and from the current ASI state register when it is set.

The address is physical and is issued in the nucleus context, so no translation stands between the unit and memory. Translation supplies only the cacheable attribute. While a load is outstanding, the unit refuses any new instruction.

Top module: `quad_load_unit`

## Requirements
- R1: After reset, `issue_ready` is 1, and `mem_req_valid`, `rf_we`, `exc_priv`, `exc_align` and `exc_access` are all 0.
- R2: An accepted instruction word is acted on only when all of the following hold:
  - bits 31:30 are 11;
  - bit 4 of op3 (bits 24:19) is 1;
  - the selected ASI is 0x34 or 0x3C.

  The selected ASI is bits 12:5 when bit 13 is 0, and `asi_state` when bit 13 is 1. Any other word raises no exception and makes no memory request.
- R3: The effective address is `rs1_val + rs2_val` when bit 13 is 0. When bit 13 is 1, it is `rs1_val` plus the sign-extended value of bits 12:0. `mem_req_addr` carries its low ADDR_W bits.
- R4: When `priv` is 0, a recognised instruction raises `exc_priv`, whatever else is wrong with it.
- R5: When `priv` is 1 and the address is not a multiple of 16, the unit raises `exc_align` and makes no memory request.
- R6: When the address is aligned and op3 is not 010011, the unit raises `exc_access`.
- R7: When the instruction is privileged, aligned and has op3 010011, a 0 on `cacheable` raises `exc_access` with no memory request.
- R8: For each recognised instruction, at most one exception flag is high. That flag is high for exactly the one cycle after acceptance, and it never coincides with `rf_we`.
- R9: The response bus carries the lower-addressed doubleword in bits 127:64 and the higher-addressed doubleword in bits 63:0. For ASI 0x34, a single `rf_we` cycle does two things:
  - it writes bits 127:64 to register rd with bit 0 cleared;
  - it writes bits 63:0 to register rd with bit 0 set.

  That cycle is one cycle after the response.
- R10: For ASI 0x3C, the same pair of registers is written, but each 64-bit half is byte-reversed first.
- R11: From acceptance until the register write, `issue_ready` is 0. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R12: Each load that passes all checks produces exactly one request cycle and one register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word and operands are valid |
| issue_ready | output | 1 | Unit can accept an instruction |
| insn | input | 32 | Instruction word |
| rs1_val | input | 64 | First source operand value |
| rs2_val | input | 64 | Second source operand value (used when bit 13 is 0) |
| asi_state | input | 8 | Current ASI state register |
| priv | input | 1 | Processor is in privileged mode |
| cacheable | input | 1 | Target is cacheable, from translation |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Physical address of the quadword |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 128 | Read data, lower address in bits 127:64 |
| rf_we | output | 1 | Commit both register writes |
| rf_waddr_even | output | 5 | Even destination register |
| rf_wdata_even | output | 64 | Data for the even register |
| rf_waddr_odd | output | 5 | Odd destination register |
| rf_wdata_odd | output | 64 | Data for the odd register |
| exc_priv | output | 1 | Privileged-ASI trap |
| exc_align | output | 1 | Address not aligned |
| exc_access | output | 1 | Data access exception |

## Verification
The assertions assume the memory side behaves: `mem_rsp_valid` arrives only after a request has been accepted, and only once per request. The handshake properties would not hold against a memory that answers unasked. The bench drives the memory port from its load tasks alone. It raises `mem_req_ready` only while a request is showing, and pulses `mem_rsp_valid` once per request. Instructions offered while the unit is busy are meant to be refused, and the bench lowers `issue_valid` before the unit returns to idle.

// File: rtl/quad_load_unit.sv
module quad_load_unit #(
  parameter int ADDR_W = 40,
  parameter int DW = 64,
  parameter logic [7:0] ASI_BE = 8'h34,
  parameter logic [7:0] ASI_LE = 8'h3C,
  localparam int QW = 2 * DW,
  localparam int NB = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [31:0]       insn,
  input  logic [DW-1:0]     rs1_val,
  input  logic [DW-1:0]     rs2_val,
  input  logic [7:0]        asi_state,
  input  logic              priv,
  input  logic              cacheable,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [QW-1:0]     mem_rsp_data,
  output logic              rf_we,
  output logic [4:0]        rf_waddr_even,
  output logic [DW-1:0]     rf_wdata_even,
  output logic [4:0]        rf_waddr_odd,
  output logic [DW-1:0]     rf_wdata_odd,
  output logic              exc_priv,
  output logic              exc_align,
  output logic              exc_access
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = v[DW-8-8*b +: 8];
    return r;
  endfunction

  logic [7:0]    asi;
  logic [DW-1:0] offset, ea;
  logic          is_alt, is_quad, hit, e_priv, e_align, e_op, e_nc, go;
  logic [3:0]    rd_q;
  logic          le_q;
  logic [ADDR_W-1:0] addr_q;
  logic          unused_bits;

  assign asi     = insn[13] ? asi_state : insn[12:5];
  assign offset  = insn[13] ? {{(DW-13){insn[12]}}, insn[12:0]} : rs2_val;
  assign ea      = rs1_val + offset;
  assign is_alt  = (insn[31:30] == 2'b11) && insn[23];
  assign is_quad = (asi == ASI_BE) || (asi == ASI_LE);
  assign hit     = issue_valid && issue_ready && is_alt && is_quad;

  assign e_priv  = !priv;
  assign e_align = ea[3:0] != 4'd0;
  assign e_op    = insn[24:19] != 6'b010011;
  assign e_nc    = !cacheable;
  assign go      = hit && !e_priv && !e_align && !e_op && !e_nc;

  assign issue_ready   = state == S_IDLE;
  assign mem_req_valid = state == S_REQ;
  assign mem_req_addr  = addr_q;
  assign unused_bits   = ^{insn[18:14], ea[DW-1:ADDR_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      addr_q        <= '0;
      rd_q          <= '0;
      le_q          <= 1'b0;
      rf_we         <= 1'b0;
      rf_waddr_even <= '0;
      rf_waddr_odd  <= '0;
      rf_wdata_even <= '0;
      rf_wdata_odd  <= '0;
      exc_priv      <= 1'b0;
      exc_align     <= 1'b0;
      exc_access    <= 1'b0;
    end else begin
      rf_we      <= 1'b0;
      exc_priv   <= hit && e_priv;
      exc_align  <= hit && !e_priv && e_align;
      exc_access <= hit && !e_priv && !e_align && (e_op || e_nc);
      case (state)
        S_IDLE: if (go) begin
          state  <= S_REQ;
          addr_q <= ea[ADDR_W-1:0];
          rd_q   <= insn[29:26];
          le_q   <= asi == ASI_LE;
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          state         <= S_IDLE;
          rf_we         <= 1'b1;
          rf_waddr_even <= {rd_q, 1'b0};
          rf_waddr_odd  <= {rd_q, 1'b1};
          rf_wdata_even <= le_q ? swap_bytes(mem_rsp_data[QW-1:DW]) : mem_rsp_data[QW-1:DW];
          rf_wdata_odd  <= le_q ? swap_bytes(mem_rsp_data[DW-1:0])  : mem_rsp_data[DW-1:0];
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module quad_load_unit_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rf_we,
  input logic [4:0]        rf_waddr_even,
  input logic [4:0]        rf_waddr_odd,
  input logic              exc_priv,
  input logic              exc_align,
  input logic              exc_access
);

  AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_priv, exc_align, exc_access})); // R8
  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !(exc_priv || exc_align || exc_access)); // R8
  AST_PAIR_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr_even[0] == 1'b0 && rf_waddr_odd == (rf_waddr_even | 5'd1))); // R9
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[3:0] == 4'd0)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_BUSY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !issue_ready); // R11
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R12

endmodule

bind quad_load_unit quad_load_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_quad_load_unit.sv
`timescale 1ns/1ps
module tb_quad_load_unit;
  localparam int AW = 40;

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, priv = 1, cacheable = 1;
  logic [31:0] insn = 0;
  logic [63:0] rs1_val = 0, rs2_val = 0;
  logic [7:0] asi_state = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [127:0] mem_rsp_data = 0;
  logic issue_ready, mem_req_valid, rf_we, exc_priv, exc_align, exc_access;
  logic [AW-1:0] mem_req_addr;
  logic [4:0] rf_waddr_even, rf_waddr_odd;
  logic [63:0] rf_wdata_even, rf_wdata_odd;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_load_unit #(.ADDR_W(AW)) dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rev8(input logic [63:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24], v[39:32], v[47:40], v[55:48], v[63:56]};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] hi, input logic [4:0] rd, input logic [5:0] op3,
                                     input logic i, input logic [7:0] asi, input logic [12:0] simm);
    return {hi, rd, op3, 5'd3, i, i ? simm : {asi, 5'd7}};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] st, input logic p, input logic c);
    @(negedge clk);
    insn = w; rs1_val = a; rs2_val = b; asi_state = st; priv = p; cacheable = c;
    issue_valid = 1;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 ready", issue_ready, 1);
    chk("R1 req", mem_req_valid, 0);
    chk("R1 we", rf_we, 0);
    chk("R1 exc", {exc_priv, exc_align, exc_access}, 0);
  endtask

  task automatic t_load(input string req, input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] st, input logic [AW-1:0] exp_addr, input logic [127:0] d,
                        input logic le, input int stall);
    logic [4:0] rd = w[29:25];
    issue(w, a, b, st, 1, 1);
    chk({req, " R3 addr"}, mem_req_addr, exp_addr);
    chk({req, " R12 req"}, mem_req_valid, 1);
    chk({req, " R11 busy"}, issue_ready, 0);
    chk({req, " R8 no exc"}, {exc_priv, exc_align, exc_access}, 0);
    for (int k = 0; k < stall; k++) begin
      issue_valid = 1; insn = mk(2'b11, 5'd9, 6'b010011, 0, 8'h34, 0);
      @(posedge clk); @(negedge clk);
      chk({req, " R11 hold"}, {mem_req_valid, mem_req_addr}, {1'b1, exp_addr});
      chk({req, " R11 refuse"}, issue_ready, 0);
    end
    issue_valid = 0;
    mem_req_ready = 1;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 0;
    chk({req, " R12 single req"}, mem_req_valid, 0);
    chk({req, " R11 busy wait"}, issue_ready, 0);
    mem_rsp_valid = 1; mem_rsp_data = d;
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 0;
    chk({req, " R9 we"}, rf_we, 1);
    chk({req, " R9 even reg"}, rf_waddr_even, {rd[4:1], 1'b0});
    chk({req, " R9 odd reg"}, rf_waddr_odd, {rd[4:1], 1'b1});
    if (le) begin
      chk({req, " R10 even data"}, rf_wdata_even, rev8(d[127:64]));
      chk({req, " R10 odd data"}, rf_wdata_odd, rev8(d[63:0]));
    end else begin
      chk({req, " R9 even data"}, rf_wdata_even, d[127:64]);
      chk({req, " R9 odd data"}, rf_wdata_odd, d[63:0]);
    end
    chk({req, " R11 ready again"}, issue_ready, 1);
    @(posedge clk); @(negedge clk);
    chk({req, " R12 one write"}, {rf_we, mem_req_valid}, 0);
  endtask

  task automatic t_exc(input string req, input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] st, input logic p, input logic c, input logic [2:0] exp);
    issue(w, a, b, st, p, c);
    chk({req, " flags"}, {exc_priv, exc_align, exc_access}, exp);
    chk({req, " no req"}, mem_req_valid, 0);
    chk({req, " ready"}, issue_ready, 1);
    @(posedge clk); @(negedge clk);
    chk({req, " R8 one cycle"}, {exc_priv, exc_align, exc_access, mem_req_valid, rf_we}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();

    t_load("R9 be reg-reg", mk(2'b11, 5'd5, 6'b010011, 0, 8'h34, 0), 64'h1000, 64'h230, 8'h00,
           40'h1230, 128'h0011223344556677_8899AABBCCDDEEFF, 0, 0);
    t_load("R10 le imm", mk(2'b11, 5'd10, 6'b010011, 1, 8'h00, 13'h1FF0), 64'h2010, 64'hDEAD, 8'h3C,
           40'h2000, 128'h0102030405060708_F1F2F3F4F5F6F7F8, 1, 0);
    t_load("R11 stall", mk(2'b11, 5'd31, 6'b010011, 0, 8'h3C, 0), 64'hFF_0000_0000_0040, 64'h0, 8'h34,
           40'h00_0000_0040, 128'hA5A5A5A5_5A5A5A5A_12345678_9ABCDEF0, 1, 3);

    t_exc("R4 priv first", mk(2'b11, 5'd2, 6'b010000, 0, 8'h34, 0), 64'h1003, 0, 0, 0, 0, 3'b100);
    t_exc("R5 misaligned", mk(2'b11, 5'd2, 6'b010000, 0, 8'h3C, 0), 64'h1008, 0, 0, 1, 0, 3'b010);
    t_exc("R5 imm misaligned", mk(2'b11, 5'd2, 6'b010011, 1, 8'h00, 13'h0004), 64'h1000, 0, 8'h34, 1, 1, 3'b010);
    t_exc("R6 wrong op", mk(2'b11, 5'd2, 6'b010000, 0, 8'h34, 0), 64'h1000, 0, 0, 1, 1, 3'b001);
    t_exc("R7 noncacheable", mk(2'b11, 5'd2, 6'b010011, 0, 8'h34, 0), 64'h1000, 0, 0, 1, 0, 3'b001);

    t_exc("R2 other asi", mk(2'b11, 5'd2, 6'b010011, 0, 8'h80, 0), 64'h1003, 0, 0, 0, 0, 3'b000);
    t_exc("R2 imm asi reg", mk(2'b11, 5'd2, 6'b010011, 1, 8'h34, 13'h0003), 64'h1000, 0, 8'h24, 0, 0, 3'b000);
    t_exc("R2 not alt", mk(2'b11, 5'd2, 6'b000011, 0, 8'h34, 0), 64'h1003, 0, 0, 0, 0, 3'b000);
    t_exc("R2 wrong format", mk(2'b10, 5'd2, 6'b010011, 0, 8'h34, 0), 64'h1003, 0, 0, 0, 0, 3'b000);

    t_load("R9 after exc", mk(2'b11, 5'd0, 6'b010011, 0, 8'h34, 0), 64'h80, 64'h80, 8'h00,
           40'h100, 128'hFEDCBA98_76543210_0F1E2D3C_4B5A6978, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule